// File: doc/BRIEF.md
# Pre-Trigger Ring Buffer Capture Controller

This block is the acquisition memory controller of a digitizer whose converter runs without pause. Every clock one converter word arrives on `sample_i`. Once the block has been armed, it writes each word into a circular buffer of `DEPTH` entries, and the write address wraps at the end of the buffer. A trigger pulse freezes the current write address. The block then stores a programmed number of further words and stops. The buffer then holds the stretch of signal that led up to the event, followed by the stretch that came after it.

Software, or a downstream transfer engine, waits for `done_o` and then pulses `rd_en_i` once per word. It receives the capture in time order, from the oldest pre-event word to the last post-event word. The split is set by `post_len_i`, which is latched when the block is armed. The post-event part holds that many words, and the pre-event part holds `DEPTH` minus that many. A trigger is honoured only once the pre-event part holds fresh data. `pre_valid_o` reports when that is the case.

The controller has five named states:
- IDLE: after reset.
- FILL: the pre-event part is being filled.
- ARMED: writing continues while the block waits for a trigger.
- POST: the post-event words are being written.
- DONE: the capture is frozen and can be read.

The transitions are:
- IDLE→FILL, ARMED→FILL, POST→FILL and DONE→FILL on arm.
- FILL→FILL on arm, which restarts the fill count.
- FILL→ARMED when the fill is complete.
- ARMED→POST on a trigger when the post length is above one.
- ARMED→DONE on a trigger when the post length is one.
- POST→DONE after the last post-event write.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset the block is in IDLE. `done_o`=0, `pre_valid_o`=0 and `trig_addr_o`=0. A trigger in IDLE changes none of them.
- R2: An arm pulse, accepted in any state, moves the block to FILL. From the next cycle on, `done_o`=0 and `pre_valid_o`=0. The same edge latches `post_len_i` as the post length P, and a value of 0 is taken as P=1.
- R3: In FILL, ARMED and POST the block writes one sample per clock at the write address. That address starts at 0 after reset, advances by one per write and wraps from `DEPTH`-1 to 0.
- R4: Call the arm edge edge 0. The FILL state writes exactly `DEPTH`-P samples, on edges 1 to `DEPTH`-P, and a trigger at any of these edges is ignored. `pre_valid_o` reads 1 after edge `DEPTH`-P and 0 before it.
- R5: A trigger accepted in ARMED copies the current write address to `trig_addr_o`. The sample written on that same edge is the first post-event sample.
- R6: Exactly P post-event samples are written. With the trigger at edge d after arming, `done_o` is 0 after edge d+P-2 and 1 after edge d+P-1.
- R7: In DONE nothing is written and triggers are ignored. `done_o`, `trig_addr_o` and the stored capture are held until the next arm.
- R8: In DONE, `rd_data_o` shows the entry at (trigger address − (`DEPTH`−P) + n) mod `DEPTH`, where n is the number of accepted read strobes. The first word is the oldest pre-event sample. After `DEPTH` strobes the readout wraps back to the first word.
- R9: Read strobes outside DONE are ignored. The read position restarts at the oldest word each time DONE is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm pulse; restarts a capture |
| post_len_i | input | AW | Post-event word count, latched on arm |
| trig_i | input | 1 | Trigger pulse, already aligned to the clock |
| sample_i | input | DATA_W | Converter word, one per clock |
| rd_en_i | input | 1 | Read strobe; advances the readout by one word |
| rd_data_o | output | DATA_W | Current readout word |
| trig_addr_o | output | AW | Write address latched at the trigger |
| pre_valid_o | output | 1 | Pre-event part holds fresh data |
| done_o | output | 1 | Capture complete, buffer frozen |

## Verification
A fill count that ends one word early or late moves the edge at which `pre_valid_o` rises. It also changes whether a trigger near that edge is taken, and both effects are visible within a cycle. A wrong post count shifts the rise of `done_o` by the same number of cycles. A wrong read base or wrong wrap shows up in the first readout word, because the bench drives a running count as the sample stream and so knows which value must come first. A state that keeps writing in DONE corrupts the frozen buffer. That corruption appears as a mismatch when the capture is read a second time, twenty cycles later.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_ARMED = 3'd2,
        ST_POST  = 3'd3,
        ST_DONE  = 3'd4
    } tcap_state_e;
endpackage

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
    import tcap_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              trig_i,
    input  logic [AW-1:0]     post_len_i,
    output tcap_state_e       state_o,
    output logic              wr_en_o,
    output logic              trig_take_o,
    output logic [AW-1:0]     pre_len_o,
    output logic              pre_valid_o,
    output logic              done_o
);
    tcap_state_e       state_q, state_d;
    logic [AW-1:0]     cnt_q;
    logic [AW-1:0]     post_q;
    logic [AW:0]       pre_full;

    assign pre_full  = (AW+1)'(DEPTH) - {1'b0, post_q};
    assign pre_len_o = pre_full[AW-1:0];
    assign state_o   = state_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_i) state_d = ST_FILL;
            ST_FILL:  begin
                if (arm_i)                           state_d = ST_FILL;
                else if (cnt_q == pre_len_o - 1'b1)  state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (arm_i)       state_d = ST_FILL;
                else if (trig_i) state_d = (post_q == AW'(1)) ? ST_DONE : ST_POST;
            end
            ST_POST:  begin
                if (arm_i)                        state_d = ST_FILL;
                else if (cnt_q == post_q - 1'b1)  state_d = ST_DONE;
            end
            ST_DONE:  if (arm_i) state_d = ST_FILL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // post length latch and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_q <= AW'(1);
            cnt_q  <= '0;
        end else if (arm_i) begin
            post_q <= (post_len_i == '0) ? AW'(1) : post_len_i;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_FILL:  cnt_q <= cnt_q + 1'b1;
                ST_ARMED: if (trig_i) cnt_q <= AW'(1);
                ST_POST:  cnt_q <= cnt_q + 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en_o     = 1'b0;
        trig_take_o = 1'b0;
        pre_valid_o = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FILL:  wr_en_o = 1'b1;
            ST_ARMED: begin
                wr_en_o     = 1'b1;
                pre_valid_o = 1'b1;
                trig_take_o = trig_i && !arm_i;
            end
            ST_POST:  begin
                wr_en_o     = 1'b1;
                pre_valid_o = 1'b1;
            end
            ST_DONE:  begin
                pre_valid_o = 1'b1;
                done_o      = 1'b1;
            end
            default:  ;
        endcase
    end

    assert_arm_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> state_q == ST_FILL);

    assert_fill_ignores_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && trig_i && !arm_i) |=> (state_q == ST_FILL || state_q == ST_ARMED));

    assert_prevalid_from_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_valid_o) |-> $past(state_q) == ST_FILL);

    assert_post_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_POST |-> (cnt_q < post_q && cnt_q != '0));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !arm_i) |=> state_q == ST_DONE);
endmodule

// File: rtl/tcap_ring.sv
module tcap_ring #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              trig_take_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [AW-1:0]     wr_addr_o,
    output logic [AW-1:0]     trig_addr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q;
    logic [AW-1:0]     tp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            tp_q <= '0;
        end else begin
            if (wr_en_i)     wp_q <= wp_q + 1'b1;
            if (trig_take_i) tp_q <= wp_q;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wp_q] <= sample_i;
    end

    assign wr_addr_o   = wp_q;
    assign trig_addr_o = tp_q;
    assign rd_data_o   = mem[rd_addr_i];

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wp_q == AW'(DEPTH-1)) |=> wp_q == '0);

    assert_idle_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(wp_q));
endmodule

// File: rtl/tcap_reader.sv
module tcap_reader #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] trig_addr_i,
    input  logic [AW-1:0] pre_len_i,
    output logic [AW-1:0] rd_addr_o
);
    logic [AW-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             off_q <= '0;
        else if (!done_i)       off_q <= '0;
        else if (rd_en_i)       off_q <= off_q + 1'b1;
    end

    assign rd_addr_o = trig_addr_i - pre_len_i + off_q;

    assert_offset_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && $past(!done_i)) |-> rd_addr_o == trig_addr_i - pre_len_i);
endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import tcap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [AW-1:0]     post_len_i,
    input  logic              trig_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [AW-1:0]     trig_addr_o,
    output logic              pre_valid_o,
    output logic              done_o
);
    tcap_state_e   state;
    logic          wr_en;
    logic          trig_take;
    logic [AW-1:0] pre_len;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    tcap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .trig_i      (trig_i),
        .post_len_i  (post_len_i),
        .state_o     (state),
        .wr_en_o     (wr_en),
        .trig_take_o (trig_take),
        .pre_len_o   (pre_len),
        .pre_valid_o (pre_valid_o),
        .done_o      (done_o)
    );

    tcap_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .sample_i    (sample_i),
        .trig_take_i (trig_take),
        .rd_addr_i   (rd_addr),
        .wr_addr_o   (wr_addr),
        .trig_addr_o (trig_addr_o),
        .rd_data_o   (rd_data_o)
    );

    tcap_reader #(.AW(AW)) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done_o),
        .rd_en_i     (rd_en_i),
        .trig_addr_i (trig_addr_o),
        .pre_len_i   (pre_len),
        .rd_addr_o   (rd_addr)
    );

    // the oldest word sits where the next write would have gone
    assert_read_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> rd_addr == wr_addr);

    assert_done_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> !wr_en);
endmodule

// File: tb/trig_capture_ctrl_tb.sv
`timescale 1ns/1ps
module trig_capture_ctrl_tb;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int AW     = 4;
    localparam int NVEC   = 7;
    // post length, early (ignored) trigger step or 0, accepted trigger step
    localparam int VEC [NVEC][3] = '{
        '{8,  0,  9},
        '{8,  5,  20},
        '{1,  0,  16},
        '{15, 0,  2},
        '{4,  12, 13},
        '{0,  0,  40},
        '{12, 3,  30}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm_i = 1'b0;
    logic [AW-1:0]     post_len_i = '0;
    logic              trig_i = 1'b0;
    logic [DATA_W-1:0] sample_i = '0;
    logic              rd_en_i = 1'b0;
    logic [DATA_W-1:0] rd_data_o;
    logic [AW-1:0]     trig_addr_o;
    logic              pre_valid_o;
    logic              done_o;

    int total = 0;
    int bad   = 0;
    int wp    = 0;

    always #2.5 clk = ~clk;

    trig_capture_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .post_len_i(post_len_i),
        .trig_i(trig_i), .sample_i(sample_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .trig_addr_o(trig_addr_o),
        .pre_valid_o(pre_valid_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        sample_i = sample_i + 8'd1;
    endtask

    task automatic read_all(input int tv, input int p, input string req);
        for (int j = 0; j < DEPTH; j++) begin
            int e;
            e = (tv + p - DEPTH + j + 256) & 255;
            chk(rd_data_o == DATA_W'(e), req, rd_data_o, e);
            rd_en_i = 1'b1;
            tick();
            rd_en_i = 1'b0;
        end
        // readout wraps back to the oldest word
        chk(rd_data_o == DATA_W'((tv + p - DEPTH + 256) & 255), "R8 wrap",
            rd_data_o, (tv + p - DEPTH + 256) & 255);
    endtask

    task automatic run_capture(input int post_in, input int d_early, input int d, output int tv);
        int p, pre, wp0;
        p   = (post_in == 0) ? 1 : post_in;
        pre = DEPTH - p;
        wp0 = wp;
        tv  = 0;
        post_len_i = AW'(post_in);
        arm_i = 1'b1;
        tick();
        arm_i = 1'b0;
        chk(done_o == 1'b0 && pre_valid_o == 1'b0, "R2 arm clears", {done_o, pre_valid_o}, 0);
        for (int k = 1; k <= d + p + 1; k++) begin
            trig_i  = (k == d) || (k == d_early && d_early > 0);
            rd_en_i = (k <= d + p - 1);   // strobes outside DONE, R9
            if (k == d) tv = int'(sample_i);
            tick();
            trig_i  = 1'b0;
            rd_en_i = 1'b0;
            if (k == pre - 1 && pre >= 2) chk(pre_valid_o == 1'b0, "R4 early", pre_valid_o, 0);
            if (k == pre) chk(pre_valid_o == 1'b1, "R4 valid", pre_valid_o, 1);
            if (k == d) chk(int'(trig_addr_o) == (wp0 + d - 1) % DEPTH, "R5 addr",
                            trig_addr_o, (wp0 + d - 1) % DEPTH);
            if (k == d + p - 2 && k >= 1) chk(done_o == 1'b0, "R6 not yet", done_o, 0);
            if (k == d + p - 1) chk(done_o == 1'b1, "R6 done", done_o, 1);
        end
        wp = (wp0 + d + p - 1) % DEPTH;
        read_all(tv, p, "R3 R8 data");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        wp = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int tv;
        int ta;
        do_reset();
        chk(done_o == 1'b0 && pre_valid_o == 1'b0 && trig_addr_o == '0, "R1 reset",
            {done_o, pre_valid_o, trig_addr_o}, 0);
        trig_i = 1'b1;
        repeat (3) tick();
        trig_i = 1'b0;
        tick();
        chk(done_o == 1'b0 && pre_valid_o == 1'b0 && trig_addr_o == '0, "R1 idle trig",
            {done_o, pre_valid_o, trig_addr_o}, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_capture(VEC[v][0], VEC[v][1], VEC[v][2], tv);
            repeat (2) tick();
        end

        // R7: hold in DONE while triggers and samples keep coming
        ta = int'(trig_addr_o);
        for (int k = 0; k < 20; k++) begin
            trig_i = k[0];
            tick();
        end
        trig_i = 1'b0;
        chk(done_o == 1'b1, "R7 done held", done_o, 1);
        chk(int'(trig_addr_o) == ta, "R7 addr held", trig_addr_o, ta);
        read_all(tv, VEC[NVEC-1][0], "R7 frozen data");

        // R2: re-arm in the middle of POST
        do_reset();
        post_len_i = AW'(8);
        arm_i = 1'b1;
        tick();
        arm_i = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            trig_i = (k == 10);
            tick();
        end
        trig_i = 1'b0;
        chk(done_o == 1'b0 && pre_valid_o == 1'b1, "R2 in post", {done_o, pre_valid_o}, 1);
        wp = 11;   // ten fill/armed writes plus the write on the re-arm edge
        run_capture(5, 0, 12, tv);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule